// File: doc/BRIEF.md
# Mixed-Criticality Egress Link Scheduler

This block decides which of four egress queues may start the next message on a single outgoing link. Queue 0 carries periodic, time-triggered messages. Queues 1 and 2 carry rate-constrained sporadic traffic at high and low priority. Queue 3 carries best-effort traffic. Each queue shows whether its head is valid and how many link cycles that head occupies. Once a message starts, it keeps the link until it ends. When a message starts, the block raises a one-cycle start strobe for that queue, which also serves as the dequeue signal. It holds a grant for that queue for as long as the message lasts.

Periodic releases come from a small schedule table. Each enabled entry has a period, a first release time and a slot length, all measured against a global time input that advances by one per clock. The earliest pending release over all enabled entries is the next slot time. A mode input selects one of two policies. In the guarded policy, lower-criticality traffic may not start if it would overrun the next slot, and it stays blocked for the slot length after each release. This leaves the link idle when the periodic message is due. In the shuffling policy, plain priority applies. A periodic message then waits for at most the one lower message already on the link, and the lower traffic gets better use of the link.

Top module: `crit_egress_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, grant_o, start_o and busy_o are all zero.
- R2: At most one bit of grant_o is set. A start_o pulse is one-hot, lasts one cycle, and equals grant_o in that cycle.
- R3: A started message keeps its grant for exactly its length in cycles, taken from its q_len_i field (bits 8q+7..8q for queue q). A length of zero counts as one. Nothing preempts it. The next message may start in the cycle straight after the last grant cycle.
- R4: In shuffling mode (guard_mode_i = 0), the winner among eligible queues is the released periodic queue 0, then sporadic queue 1, then sporadic queue 2, then best-effort queue 3.
- R5: A table entry with period P and phase F releases at times F, F+P, F+2P, and so on. Queue 0 starts only after a release, at most once per release. With the link free, its start strobe appears two time units after the release time.
- R6: In guarded mode (guard_mode_i = 1), queues 1 to 3 may start only when the current time plus the head length is no later than the next release time.
- R7: In guarded mode, queues 1 to 3 are blocked for the slot length of an entry, counted in cycles after its release, even when queue 0 is empty. In shuffling mode the slot length has no effect.
- R8: In shuffling mode, a lower message that started before a release delays the periodic start until that message ends, and the periodic message then starts back-to-back.
- R9: The mode input is taken only in cycles when the link is free. A change made during a transmission has no effect on the decision at the end of that transmission.
- R10: The next release time is the minimum over enabled entries only. A disabled entry (tbl_en_i = 0 when written) never releases and never blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| time_i | input | TW | Global time, one count per clock |
| guard_mode_i | input | 1 | 1 = guarded policy, 0 = shuffling policy |
| tbl_we_i | input | 1 | Schedule table write strobe |
| tbl_idx_i | input | IW | Table entry index |
| tbl_en_i | input | 1 | Entry enable |
| tbl_period_i | input | TW | Entry period |
| tbl_phase_i | input | TW | Entry first release time |
| tbl_slot_i | input | LW | Entry slot length, in cycles |
| q_valid_i | input | 4 | Head valid, one bit per queue |
| q_len_i | input | 4*LW | Head lengths, LW bits per queue |
| grant_o | output | 4 | Queue currently owning the link |
| start_o | output | 4 | One-cycle start strobe, also the dequeue signal |
| busy_o | output | 1 | Link occupied |

## Verification
The assertions check on every cycle that the grant is one-hot or idle, that a start strobe matches the grant and follows a valid head, and that no grant changes in the middle of a message. They also check that in shuffling mode a lower sporadic or best-effort start never passes a waiting higher queue. Only the directed scenarios can show the timing relations. These are the exact cycle of each periodic start after a release, the fit test against the next slot, the blocking interval set by the slot length, the minimum over enabled entries, and the rule that the mode is taken only while the link is free.

// File: rtl/crit_egress_pkg.sv
package crit_egress_pkg;
  localparam int NQ = 4;
  localparam int QW = 2;
  // queue index order matters: lower index wins
  localparam logic [QW-1:0] Q_PER = 2'd0;
  localparam logic [QW-1:0] Q_SPH = 2'd1;
  localparam logic [QW-1:0] Q_SPL = 2'd2;
  localparam logic [QW-1:0] Q_BE  = 2'd3;
endpackage

// File: rtl/egs_slot_table.sv
module egs_slot_table #(
  parameter int TW = 16,
  parameter int LW = 8,
  parameter int NE = 8,
  localparam int IW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] time_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic          en_i,
  input  logic [TW-1:0] period_i,
  input  logic [TW-1:0] phase_i,
  input  logic [LW-1:0] slot_i,
  output logic          hit_o,
  output logic [LW-1:0] hit_slot_o,
  output logic [TW-1:0] next_o,
  output logic          next_vld_o
);
  logic [NE-1:0]         en_r;
  logic [NE-1:0][TW-1:0] per_r;
  logic [NE-1:0][TW-1:0] due_r;
  logic [NE-1:0][LW-1:0] slot_r;
  logic [NE-1:0]         hit;

  for (genvar e = 0; e < NE; e++) begin : g_ent
    assign hit[e] = en_r[e] && (time_i >= due_r[e]);

    always_ff @(posedge clk) begin
      if (rst) begin
        en_r[e]   <= 1'b0;
        per_r[e]  <= '0;
        due_r[e]  <= '0;
        slot_r[e] <= '0;
      end else if (we_i && idx_i == IW'(e)) begin
        en_r[e]   <= en_i;
        per_r[e]  <= period_i;
        due_r[e]  <= phase_i;
        slot_r[e] <= slot_i;
      end else if (hit[e]) begin
        due_r[e] <= due_r[e] + per_r[e];
      end
    end
  end

  always_comb begin
    hit_o      = |hit;
    hit_slot_o = '0;
    next_o     = '0;
    next_vld_o = 1'b0;
    for (int e = 0; e < NE; e++) begin
      if (hit[e] && slot_r[e] > hit_slot_o) hit_slot_o = slot_r[e];
      if (en_r[e] && (!next_vld_o || due_r[e] < next_o)) begin
        next_o     = due_r[e];
        next_vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/egs_arbiter.sv
module egs_arbiter import crit_egress_pkg::*; #(
  parameter int TW = 16,
  parameter int LW = 8
) (
  input  logic                   guard_i,
  input  logic [TW-1:0]          time_i,
  input  logic                   win_open_i,
  input  logic                   pend_i,
  input  logic [NQ-1:0]          valid_i,
  input  logic [NQ-1:0][LW-1:0]  len_i,
  input  logic [TW-1:0]          next_i,
  input  logic                   next_vld_i,
  output logic                   pick_vld_o,
  output logic [QW-1:0]          pick_o
);
  logic [NQ-1:0] elig;

  assign elig[0] = valid_i[0] && pend_i;

  for (genvar q = 1; q < NQ; q++) begin : g_low
    logic [TW:0] end_t;
    logic        fits;
    assign end_t = {1'b0, time_i} + (TW+1)'(len_i[q]);
    assign fits  = !next_vld_i || (end_t <= {1'b0, next_i});
    assign elig[q] = valid_i[q] && (!guard_i || (win_open_i && fits));
  end

  always_comb begin
    pick_vld_o = 1'b0;
    pick_o     = '0;
    for (int q = NQ-1; q >= 0; q--) begin
      if (elig[q]) begin
        pick_vld_o = 1'b1;
        pick_o     = QW'(q);
      end
    end
  end
endmodule

// File: rtl/crit_egress_sched.sv
module crit_egress_sched import crit_egress_pkg::*; #(
  parameter int TW = 16,
  parameter int LW = 8,
  parameter int NE = 8,
  localparam int IW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TW-1:0]    time_i,
  input  logic             guard_mode_i,
  input  logic             tbl_we_i,
  input  logic [IW-1:0]    tbl_idx_i,
  input  logic             tbl_en_i,
  input  logic [TW-1:0]    tbl_period_i,
  input  logic [TW-1:0]    tbl_phase_i,
  input  logic [LW-1:0]    tbl_slot_i,
  input  logic [NQ-1:0]    q_valid_i,
  input  logic [NQ*LW-1:0] q_len_i,
  output logic [NQ-1:0]    grant_o,
  output logic [NQ-1:0]    start_o,
  output logic             busy_o
);
  logic [NQ-1:0][LW-1:0] len_raw;
  logic [NQ-1:0][LW-1:0] len_eff;
  logic                  hit;
  logic [LW-1:0]         hit_slot;
  logic [TW-1:0]         next_t;
  logic                  next_vld;
  logic                  pick_vld;
  logic [QW-1:0]         pick;

  logic                  busy;
  logic [LW-1:0]         cnt;
  logic [NQ-1:0]         grant_q;
  logic [NQ-1:0]         start_q;
  logic                  pend;
  logic [LW-1:0]         win_cnt;
  logic                  mode_q;
  logic                  free;
  logic                  take;

  assign len_raw = q_len_i;
  for (genvar q = 0; q < NQ; q++) begin : g_len
    assign len_eff[q] = (len_raw[q] == '0) ? LW'(1) : len_raw[q];
  end

  egs_slot_table #(.TW(TW), .LW(LW), .NE(NE)) u_tbl (
    .clk        (clk),
    .rst        (rst),
    .time_i     (time_i),
    .we_i       (tbl_we_i),
    .idx_i      (tbl_idx_i),
    .en_i       (tbl_en_i),
    .period_i   (tbl_period_i),
    .phase_i    (tbl_phase_i),
    .slot_i     (tbl_slot_i),
    .hit_o      (hit),
    .hit_slot_o (hit_slot),
    .next_o     (next_t),
    .next_vld_o (next_vld)
  );

  egs_arbiter #(.TW(TW), .LW(LW)) u_arb (
    .guard_i    (mode_q),
    .time_i     (time_i),
    .win_open_i (win_cnt == '0),
    .pend_i     (pend),
    .valid_i    (q_valid_i),
    .len_i      (len_eff),
    .next_i     (next_t),
    .next_vld_i (next_vld),
    .pick_vld_o (pick_vld),
    .pick_o     (pick)
  );

  assign free = !busy || (cnt == '0);
  assign take = free && pick_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      grant_q <= '0;
      start_q <= '0;
      pend    <= 1'b0;
      win_cnt <= '0;
      mode_q  <= 1'b0;
    end else begin
      start_q <= take ? (NQ'(1) << pick) : '0;
      if (free) begin
        mode_q <= guard_mode_i;
        if (take) begin
          busy    <= 1'b1;
          cnt     <= len_eff[pick] - LW'(1);
          grant_q <= NQ'(1) << pick;
        end else begin
          busy    <= 1'b0;
          grant_q <= '0;
        end
      end else begin
        cnt <= cnt - LW'(1);
      end
      pend <= hit || (pend && !(take && pick == Q_PER));
      if (hit) win_cnt <= hit_slot;
      else if (win_cnt != '0) win_cnt <= win_cnt - LW'(1);
    end
  end

  assign grant_o = grant_q;
  assign start_o = start_q;
  assign busy_o  = busy;
endmodule

// File: rtl/egs_checker.sv
module egs_checker #(
  parameter int NQ = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [NQ-1:0] q_valid_i,
  input logic [NQ-1:0] grant_o,
  input logic [NQ-1:0] start_o,
  input logic          mode_q
);
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  assert_start_is_grant_R2: assert property (@(posedge clk) disable iff (rst)
    (start_o != '0) |-> ($onehot(start_o) && start_o == grant_o));

  assert_start_had_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (start_o != '0) |-> (($past(q_valid_i) & start_o) == start_o));

  assert_no_preempt_R3: assert property (@(posedge clk) disable iff (rst)
    (grant_o != '0) |=> (start_o != '0 || grant_o == '0 || grant_o == $past(grant_o)));

  assert_shuffle_sph_first_R4: assert property (@(posedge clk) disable iff (rst)
    (start_o[2] && !$past(mode_q)) |-> !$past(q_valid_i[1]));

  assert_shuffle_be_last_R4: assert property (@(posedge clk) disable iff (rst)
    (start_o[3] && !$past(mode_q)) |-> !($past(q_valid_i[1]) || $past(q_valid_i[2])));
endmodule

bind crit_egress_sched egs_checker #(.NQ(4)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .q_valid_i (q_valid_i),
  .grant_o   (grant_o),
  .start_o   (start_o),
  .mode_q    (mode_q)
);

// File: tb/crit_egress_sched_tb.sv
module crit_egress_sched_tb;
  localparam int TW = 16;
  localparam int LW = 8;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] time_i = '0;
  logic          guard_mode = 1'b0;
  logic          tbl_we = 1'b0;
  logic [2:0]    tbl_idx = '0;
  logic          tbl_en = 1'b0;
  logic [TW-1:0] tbl_period = '0;
  logic [TW-1:0] tbl_phase = '0;
  logic [LW-1:0] tbl_slot = '0;
  logic [3:0]    q_valid = '0;
  logic [4*LW-1:0] q_len = '0;
  logic [3:0]    grant_o;
  logic [3:0]    start_o;
  logic          busy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int lq[16];
  int lt[16];
  int lg[16];
  int nst;

  crit_egress_sched #(.TW(TW), .LW(LW), .NE(NE)) u_dut (
    .clk(clk), .rst(rst), .time_i(time_i), .guard_mode_i(guard_mode),
    .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_en_i(tbl_en),
    .tbl_period_i(tbl_period), .tbl_phase_i(tbl_phase), .tbl_slot_i(tbl_slot),
    .q_valid_i(q_valid), .q_len_i(q_len),
    .grant_o(grant_o), .start_o(start_o), .busy_o(busy_o)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst) time_i = '0;
      else time_i = time_i + 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_dut(input logic mode);
    rst = 1'b1;
    q_valid = '0;
    q_len = '0;
    tbl_we = 1'b0;
    guard_mode = mode;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nst = 0;
  endtask

  task automatic tbl_write(input int idx, input bit en, input int per, input int ph, input int slot);
    tbl_idx = idx[2:0];
    tbl_en = en;
    tbl_period = per[TW-1:0];
    tbl_phase = ph[TW-1:0];
    tbl_slot = slot[LW-1:0];
    tbl_we = 1'b1;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic set_q(input int q, input int len);
    q_len[q*LW +: LW] = len[LW-1:0];
    q_valid[q] = 1'b1;
  endtask

  task automatic wait_time(input int t);
    while (int'(time_i) != t) @(negedge clk);
  endtask

  // logs starts; clears the valid of non-sticky queues on their start
  task automatic run_log(input int ncyc, input logic [3:0] sticky);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (grant_o != '0 && !$onehot(grant_o)) chk(0, "R2 grant one-hot", grant_o, 0);
      if (start_o != '0) begin
        int q = 0;
        chk($onehot(start_o) && start_o == grant_o, "R2 start equals grant", start_o, grant_o);
        for (int b = 0; b < 4; b++) if (start_o[b]) q = b;
        if (nst < 16) begin
          lq[nst] = q;
          lt[nst] = int'(time_i);
          lg[nst] = 0;
        end
        nst++;
        if (!sticky[q]) q_valid[q] = 1'b0;
      end
      if (grant_o != '0 && nst > 0 && nst <= 16) lg[nst-1]++;
    end
  endtask

  function automatic int nth_start(input int q, input int n);
    int k = 0;
    for (int i = 0; i < nst && i < 16; i++) begin
      if (lq[i] == q) begin
        if (k == n) return lt[i];
        k++;
      end
    end
    return -1;
  endfunction

  function automatic int nth_len(input int q, input int n);
    int k = 0;
    for (int i = 0; i < nst && i < 16; i++) begin
      if (lq[i] == q) begin
        if (k == n) return lg[i];
        k++;
      end
    end
    return -1;
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    q_valid = 4'hF;
    q_len = {4{8'd3}};
    repeat (3) @(negedge clk);
    chk(grant_o == 0 && start_o == 0 && !busy_o, "R1 outputs during reset", {grant_o, start_o}, 0);
    reset_dut(1'b0);
    @(negedge clk);
    chk(grant_o == 0 && start_o == 0 && !busy_o, "R1 outputs after reset", {grant_o, start_o}, 0);
  endtask

  task automatic t_shuffle_priority;
    reset_dut(1'b0);
    wait_time(10);
    set_q(1, 3); set_q(2, 2); set_q(3, 0);
    run_log(12, 4'b0000);
    chk(nst == 3, "R4 start count", nst, 3);
    chk(lq[0] == 1 && lq[1] == 2 && lq[2] == 3, "R4 order", lq[0]*100 + lq[1]*10 + lq[2], 123);
    chk(lt[0] == 11, "R2 first start time", lt[0], 11);
    chk(lt[1] - lt[0] == 3 && lt[2] - lt[1] == 2, "R3 back-to-back gaps", lt[2] - lt[0], 5);
    chk(lg[0] == 3 && lg[1] == 2, "R3 grant lengths", lg[0]*10 + lg[1], 32);
    chk(lg[2] == 1, "R3 zero length counts as one", lg[2], 1);
  endtask

  task automatic t_periodic_release;
    reset_dut(1'b0);
    tbl_write(0, 1, 20, 30, 0);
    wait_time(5);
    set_q(0, 2);
    run_log(60, 4'b0001);
    chk(nth_start(0, 0) == 32, "R5 first release start", nth_start(0, 0), 32);
    chk(nth_start(0, 1) == 52, "R5 second release start", nth_start(0, 1), 52);
    chk(nst == 2, "R5 one start per release", nst, 2);
    chk(nth_len(0, 0) == 2, "R3 periodic grant length", nth_len(0, 0), 2);
  endtask

  task automatic t_shuffle_delay;
    reset_dut(1'b0);
    tbl_write(0, 1, 100, 30, 5);
    wait_time(25);
    set_q(0, 2); set_q(3, 10);
    run_log(20, 4'b0001);
    chk(nth_start(3, 0) == 26, "R8 best effort starts before slot", nth_start(3, 0), 26);
    chk(nth_start(0, 0) == 36, "R8 periodic delayed by one message", nth_start(0, 0), 36);
  endtask

  task automatic t_guard_fit(input logic mode);
    reset_dut(mode);
    tbl_write(0, 1, 100, 40, 0);
    wait_time(30);
    set_q(0, 3); set_q(2, 8); set_q(3, 12);
    run_log(30, 4'b0001);
    chk(nth_start(2, 0) == 31, "R6 fitting sporadic starts", nth_start(2, 0), 31);
    if (mode) begin
      chk(nth_start(0, 0) == 42, "R6 periodic undisturbed", nth_start(0, 0), 42);
      chk(nth_start(3, 0) == 45, "R6 overrunning start held", nth_start(3, 0), 45);
    end else begin
      chk(nth_start(3, 0) == 39, "R8 shuffle lower starts", nth_start(3, 0), 39);
      chk(nth_start(0, 0) == 51, "R8 periodic waits one message", nth_start(0, 0), 51);
    end
  endtask

  task automatic t_slot_window(input logic mode);
    reset_dut(mode);
    tbl_write(0, 1, 100, 20, 6);
    wait_time(21);
    set_q(3, 2);
    run_log(15, 4'b0000);
    if (mode) chk(nth_start(3, 0) == 28, "R7 window blocks slot length", nth_start(3, 0), 28);
    else chk(nth_start(3, 0) == 22, "R7 slot ignored in shuffling", nth_start(3, 0), 22);
  endtask

  task automatic t_mode_sample;
    reset_dut(1'b0);
    tbl_write(0, 1, 100, 40, 0);
    wait_time(10);
    set_q(3, 20);
    run_log(2, 4'b0000);
    set_q(2, 15);
    guard_mode = 1'b1;
    run_log(25, 4'b0000);
    chk(nth_start(3, 0) == 11, "R9 first message start", nth_start(3, 0), 11);
    chk(nth_start(2, 0) == 31, "R9 mode change mid-message ignored", nth_start(2, 0), 31);
  endtask

  task automatic t_next_min;
    reset_dut(1'b1);
    tbl_write(0, 1, 200, 80, 0);
    tbl_write(3, 1, 200, 50, 0);
    tbl_write(5, 0, 200, 35, 0);
    wait_time(30);
    set_q(2, 10); set_q(3, 15);
    run_log(30, 4'b0000);
    chk(nth_start(2, 0) == 31, "R10 disabled entry ignored", nth_start(2, 0), 31);
    chk(nth_start(3, 0) == 52, "R10 earliest entry bounds start", nth_start(3, 0), 52);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_shuffle_priority();
    t_periodic_release();
    t_shuffle_delay();
    t_guard_fit(1'b1);
    t_guard_fit(1'b0);
    t_slot_window(1'b1);
    t_slot_window(1'b0);
    t_mode_sample();
    t_next_min();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule